// File: doc/BRIEF.md
# Precise Exception Commit Arbiter

This block sits beside an in-order pipeline and keeps a small exception record for every tracked stage: a valid bit, an exception flag, a cause code, the instruction PC and whether the instruction occupies a branch delay slot. Fault detectors in each stage pulse a raise input with a cause for the instruction currently held there. The record travels with its instruction, so a fault seen early is held until that instruction reaches the last tracked stage, the commit point. Only there is the exception taken.

Because the commit stage always holds the oldest in-flight instruction, the exception that is taken always belongs to the oldest faulting instruction, regardless of which stage detected a fault first. On a take the block pulses a trap report (PC, cause, delay-slot flag), flushes every tracked stage, and suppresses register-file and memory writes for the committing instruction in that same cycle. The instruction already past the commit point completes normally. For a fault in a delay slot, the reported PC is the preceding branch, so that the branch runs again on return.

Top module: `xc_commit_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, `trap_take`, `flush` and `kill_wr` are low; reset discards every held record.
- R2: `trap_take` is high in a cycle exactly when the commit stage (index NSTG-1) holds a valid instruction that either carries an exception or has `stg_raise[NSTG-1]` high in that cycle; a valid instruction without an exception commits with no take.
- R3: An instruction keeps the cause of its first raised fault; later raises on the same instruction, in later stages or at the commit stage, do not change the reported cause.
- R4: When several stages raise in the same cycle, or several in-flight instructions carry exceptions, the reported PC and cause are those of the oldest instruction, the one nearest commit.
- R5: A fault raised on a younger instruction produces no take until that instruction reaches the commit stage; cycles with `pipe_adv` low hold every record in place.
- R6: In a take cycle every bit of `flush` and `kill_wr` is high; in any other cycle all of them are low.
- R7: For a faulting instruction that is not in a delay slot, `trap_pc` equals its own PC and `trap_in_slot` is 0.
- R8: For a faulting instruction fetched with `fe_in_slot` = 1, `trap_pc` equals its PC minus INSN_BYTES (4 by default) and `trap_in_slot` is 1.
- R9: A raise on a stage that holds no valid instruction (a bubble or a flushed slot) is ignored and never causes a take.
- R10: A take empties every tracked stage, including the instruction being fetched in that cycle, so the cycle after a take has no take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_adv | input | 1 | Whole pipeline advances one stage this cycle |
| fe_valid | input | 1 | A valid instruction enters stage 0 on advance |
| fe_pc | input | 32 | PC of the entering instruction |
| fe_in_slot | input | 1 | Entering instruction is in a branch delay slot |
| stg_raise | input | NSTG | Per-stage fault pulse for the instruction held there |
| stg_cause | input | NSTG x 5 | Per-stage cause code, valid with its raise bit |
| trap_take | output | 1 | Exception taken this cycle |
| trap_pc | output | 32 | Restart PC: faulting PC, or the branch PC for a delay slot |
| trap_cause | output | 5 | Cause of the taken exception |
| trap_in_slot | output | 1 | Taken exception was in a delay slot |
| flush | output | NSTG | Per-stage flush, all high on a take |
| kill_wr | output | 1 | Suppress register and memory writes of the committing instruction |

## Verification
The assertions check, on every cycle, the relation between a take and the flush and write-kill outputs, that no take appears straight after reset, and that no take follows directly behind another. The choice of which fault wins, the preservation of the first cause, the holding of a younger fault across stalls, the delay-slot PC adjustment and the rejection of raises on bubbles depend on what sits in each stage, so only the bench's scenarios of staged instructions show them.

// File: rtl/xc_arb_pkg.sv
package xc_arb_pkg;
    localparam int unsigned XC_PC_W    = 32;
    localparam int unsigned XC_CAUSE_W = 5;

    typedef struct packed {
        logic                  valid;
        logic                  exc;
        logic                  in_slot;
        logic [XC_CAUSE_W-1:0] cause;
        logic [XC_PC_W-1:0]    pc;
    } xc_rec_t;
endpackage

// File: rtl/xc_stage_merge.sv
module xc_stage_merge
    import xc_arb_pkg::*;
(
    input  xc_rec_t               rec_q,
    input  logic                  raise,
    input  logic [XC_CAUSE_W-1:0] cause,
    output xc_rec_t               rec_eff
);
    // A held exception wins over a new raise; bubbles never raise.
    always_comb begin
        rec_eff = rec_q;
        if (rec_q.valid && !rec_q.exc && raise) begin
            rec_eff.exc   = 1'b1;
            rec_eff.cause = cause;
        end
    end
endmodule

// File: rtl/xc_commit_pick.sv
module xc_commit_pick
    import xc_arb_pkg::*;
#(
    parameter int unsigned INSN_BYTES = 4
) (
    input  xc_rec_t               head,
    output logic                  take,
    output logic [XC_PC_W-1:0]    epc,
    output logic [XC_CAUSE_W-1:0] ecause,
    output logic                  eslot
);
    localparam logic [XC_PC_W-1:0] STEP = XC_PC_W'(INSN_BYTES);

    always_comb begin
        take   = head.valid && head.exc;
        ecause = take ? head.cause : '0;
        eslot  = take && head.in_slot;
        if (!take)
            epc = '0;
        else if (head.in_slot)
            epc = head.pc - STEP;
        else
            epc = head.pc;
    end
endmodule

// File: rtl/xc_commit_arbiter.sv
module xc_commit_arbiter
    import xc_arb_pkg::*;
#(
    parameter int unsigned NSTG       = 4,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             pipe_adv,
    input  logic                             fe_valid,
    input  logic [XC_PC_W-1:0]               fe_pc,
    input  logic                             fe_in_slot,
    input  logic [NSTG-1:0]                  stg_raise,
    input  logic [NSTG-1:0][XC_CAUSE_W-1:0]  stg_cause,
    output logic                             trap_take,
    output logic [XC_PC_W-1:0]               trap_pc,
    output logic [XC_CAUSE_W-1:0]            trap_cause,
    output logic                             trap_in_slot,
    output logic [NSTG-1:0]                  flush,
    output logic                             kill_wr
);
    localparam int unsigned HEAD = NSTG - 1;

    typedef struct packed {
        xc_rec_t [NSTG-1:0] rec;
    } arb_state_t;

    arb_state_t st_d, st_q;
    xc_rec_t    eff [NSTG];
    logic       take_w;

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        xc_stage_merge u_merge (
            .rec_q   (st_q.rec[g]),
            .raise   (stg_raise[g]),
            .cause   (stg_cause[g]),
            .rec_eff (eff[g])
        );
    end

    xc_commit_pick #(.INSN_BYTES(INSN_BYTES)) u_pick (
        .head   (eff[HEAD]),
        .take   (take_w),
        .epc    (trap_pc),
        .ecause (trap_cause),
        .eslot  (trap_in_slot)
    );

    always_comb begin
        st_d = st_q;
        if (take_w) begin
            st_d.rec = '0;
        end else if (pipe_adv) begin
            st_d.rec[0]         = '0;
            st_d.rec[0].valid   = fe_valid;
            st_d.rec[0].in_slot = fe_valid && fe_in_slot;
            st_d.rec[0].pc      = fe_valid ? fe_pc : '0;
            for (int i = 1; i < NSTG; i++)
                st_d.rec[i] = eff[i-1];
        end else begin
            for (int i = 0; i < NSTG; i++)
                st_d.rec[i] = eff[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign trap_take = take_w;
    assign flush     = {NSTG{take_w}};
    assign kill_wr   = take_w;
endmodule

// File: rtl/xc_commit_arbiter_chk.sv
module xc_commit_arbiter_chk #(
    parameter int unsigned NSTG = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_take,
    input logic [NSTG-1:0] flush,
    input logic            kill_wr
);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!trap_take && !kill_wr && flush == '0));

    a_r6_flush_on_take: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |-> (&flush && kill_wr));

    a_r6_quiet_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_take |-> (flush == '0 && !kill_wr));

    a_r10_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> !trap_take);
endmodule

bind xc_commit_arbiter xc_commit_arbiter_chk #(.NSTG(NSTG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap_take (trap_take),
    .flush     (flush),
    .kill_wr   (kill_wr)
);

// File: tb/tb_xc_commit_arbiter.sv
module tb_xc_commit_arbiter;
    localparam int NS = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 pipe_adv = 1'b0;
    logic                 fe_valid = 1'b0;
    logic [31:0]          fe_pc = '0;
    logic                 fe_in_slot = 1'b0;
    logic [NS-1:0]        stg_raise = '0;
    logic [NS-1:0][4:0]   stg_cause = '0;
    logic                 trap_take;
    logic [31:0]          trap_pc;
    logic [4:0]           trap_cause;
    logic                 trap_in_slot;
    logic [NS-1:0]        flush;
    logic                 kill_wr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    xc_commit_arbiter dut (
        .clk(clk), .rst_n(rst_n), .pipe_adv(pipe_adv), .fe_valid(fe_valid),
        .fe_pc(fe_pc), .fe_in_slot(fe_in_slot), .stg_raise(stg_raise),
        .stg_cause(stg_cause), .trap_take(trap_take), .trap_pc(trap_pc),
        .trap_cause(trap_cause), .trap_in_slot(trap_in_slot),
        .flush(flush), .kill_wr(kill_wr)
    );

    typedef struct packed {
        logic        adv;
        logic        fv;
        logic [15:0] pc;
        logic        slot;
        logic [3:0]  raise;
        logic [19:0] causes;
        logic        etake;
        logic [15:0] epc;
        logic [4:0]  ecause;
        logic        eslot;
    } vec_t;

    function automatic logic [19:0] cz(int c3, int c2, int c1, int c0);
        return {5'(c3), 5'(c2), 5'(c1), 5'(c0)};
    endfunction

    localparam logic [19:0] NC = 20'd0;
    localparam int NV = 40;
    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b1,16'h0100,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 0
        '{1'b1,1'b1,16'h0104,1'b0,4'b0001,cz(0,0,0,3),   1'b0,16'h0000,5'd0,1'b0}, // 1 R3 first fault
        '{1'b1,1'b1,16'h0108,1'b0,4'b0010,cz(0,0,7,0),   1'b0,16'h0000,5'd0,1'b0}, // 2 R3 second fault
        '{1'b1,1'b1,16'h010C,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 3 R5 held
        '{1'b0,1'b0,16'h0000,1'b0,4'b0000,NC,            1'b1,16'h0100,5'd3,1'b0}, // 4 R3 R7
        '{1'b1,1'b1,16'h0200,1'b0,4'b1010,cz(9,0,9,0),   1'b0,16'h0000,5'd0,1'b0}, // 5 R9 R10
        '{1'b1,1'b1,16'h0204,1'b1,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 6
        '{1'b1,1'b1,16'h0208,1'b0,4'b0011,cz(0,0,4,2),   1'b0,16'h0000,5'd0,1'b0}, // 7
        '{1'b1,1'b1,16'h020C,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 8
        '{1'b0,1'b0,16'h0000,1'b0,4'b0000,NC,            1'b1,16'h0200,5'd4,1'b0}, // 9 R4 older
        '{1'b1,1'b1,16'h0300,1'b1,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 10
        '{1'b1,1'b1,16'h0304,1'b0,4'b0001,cz(0,0,0,6),   1'b0,16'h0000,5'd0,1'b0}, // 11
        '{1'b1,1'b1,16'h0308,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 12
        '{1'b1,1'b1,16'h030C,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 13
        '{1'b0,1'b0,16'h0000,1'b0,4'b0000,NC,            1'b1,16'h02FC,5'd6,1'b1}, // 14 R8
        '{1'b1,1'b1,16'h0400,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 15
        '{1'b1,1'b1,16'h0404,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 16
        '{1'b1,1'b1,16'h0408,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 17
        '{1'b1,1'b1,16'h040C,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 18
        '{1'b1,1'b1,16'h0500,1'b0,4'b1110,cz(1,10,12,0), 1'b1,16'h0400,5'd1,1'b0}, // 19 R4 R2
        '{1'b1,1'b1,16'h0600,1'b0,4'b1111,cz(3,3,3,3),   1'b0,16'h0000,5'd0,1'b0}, // 20 R10 R9
        '{1'b1,1'b0,16'h0000,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 21
        '{1'b1,1'b0,16'h0000,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 22
        '{1'b1,1'b0,16'h0000,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 23
        '{1'b1,1'b0,16'h0000,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 24 R2 clean commit
        '{1'b1,1'b0,16'h0000,1'b0,4'b1000,cz(5,0,0,0),   1'b0,16'h0000,5'd0,1'b0}, // 25 R9 bubble
        '{1'b1,1'b1,16'h0700,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 26
        '{1'b1,1'b0,16'h0000,1'b0,4'b0001,cz(0,0,0,8),   1'b0,16'h0000,5'd0,1'b0}, // 27
        '{1'b0,1'b0,16'h0000,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 28 R5 stall
        '{1'b0,1'b0,16'h0000,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 29 R5
        '{1'b0,1'b0,16'h0000,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 30 R5
        '{1'b1,1'b0,16'h0000,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 31
        '{1'b1,1'b0,16'h0000,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 32
        '{1'b0,1'b0,16'h0000,1'b0,4'b0000,NC,            1'b1,16'h0700,5'd8,1'b0}, // 33 R5
        '{1'b0,1'b0,16'h0000,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 34 R10
        '{1'b1,1'b1,16'h0A00,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 35
        '{1'b1,1'b0,16'h0000,1'b0,4'b0001,cz(0,0,0,2),   1'b0,16'h0000,5'd0,1'b0}, // 36
        '{1'b1,1'b0,16'h0000,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 37
        '{1'b1,1'b0,16'h0000,1'b0,4'b0000,NC,            1'b0,16'h0000,5'd0,1'b0}, // 38
        '{1'b0,1'b0,16'h0000,1'b0,4'b1000,cz(9,0,0,0),   1'b1,16'h0A00,5'd2,1'b0}  // 39 R3 commit raise
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic adv, input logic fv, input logic [31:0] pc,
                         input logic slot, input logic [3:0] r, input logic [19:0] c);
        pipe_adv   = adv;
        fe_valid   = fv;
        fe_pc      = pc;
        fe_in_slot = slot;
        stg_raise  = r;
        stg_cause  = c;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        // R1: outputs quiet during reset
        repeat (2) @(negedge clk);
        check("R1 take in reset", 64'(trap_take), 64'd0);
        check("R1 flush in reset", 64'({flush, kill_wr}), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 take after reset", 64'(trap_take), 64'd0);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].adv, TBL[i].fv, {16'h0, TBL[i].pc}, TBL[i].slot,
                  TBL[i].raise, TBL[i].causes);
            #1;
            check($sformatf("R2 take row %0d", i), 64'(trap_take), 64'(TBL[i].etake));
            check($sformatf("R6 flush row %0d", i), 64'({flush, kill_wr}),
                  64'({{NS{TBL[i].etake}}, TBL[i].etake}));
            if (TBL[i].etake) begin
                check($sformatf("R7 R8 pc row %0d", i), 64'(trap_pc), 64'({16'h0, TBL[i].epc}));
                check($sformatf("R3 R4 cause row %0d", i), 64'(trap_cause), 64'(TBL[i].ecause));
                check($sformatf("R8 slot row %0d", i), 64'(trap_in_slot), 64'(TBL[i].eslot));
            end
            @(negedge clk);
        end

        // R1: reset discards a faulting instruction already in flight
        drive(1'b1, 1'b1, 32'h0000_0800, 1'b0, 4'b0000, NC);
        @(negedge clk);
        drive(1'b1, 1'b0, 32'h0, 1'b0, 4'b0001, cz(0,0,0,3));
        @(negedge clk);
        drive(1'b1, 1'b0, 32'h0, 1'b0, 4'b0000, NC);
        @(negedge clk);
        @(negedge clk);
        drive(1'b0, 1'b0, 32'h0, 1'b0, 4'b0000, NC);
        #1;
        check("R2 pre-reset take", 64'(trap_take), 64'd1);
        rst_n = 1'b0;
        #1;
        check("R1 reset clears record", 64'(trap_take), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 record gone after reset", 64'(trap_take), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule